// File: doc/BRIEF.md
# Store Width Adapter for Peripheral Registers

This block sits between the 32-bit store port of a processor and a set of peripheral registers. Registers of different kinds react differently when they receive a store narrower than their own width, or a store at an address that is not aligned. The processor side presents a byte address, the full 32-bit source register value, an access size and a valid strobe. The data is never masked to the access size, so bits above the stored width still reach the bus. The top nibble of the address picks a handling class from a fixed decode map. The adapter then shapes the store into a device write with a word-aligned address, 32-bit data and four byte enables, or it discards the store.

The adapter is registered. A controller with three states (`ST_IDLE`, `ST_WRITE`, `ST_DISCARD`) accepts one store per cycle. The transition taken on an accepted store depends on whether the class keeps the store: it goes to `ST_WRITE` if kept and to `ST_DISCARD` if dropped. With no store it returns to `ST_IDLE`. Any state can reach any other on the next store, so back-to-back stores are accepted without a gap. The device write strobe is high only in `ST_WRITE`. A 64-word register bank with byte enables receives the device writes. It offers a combinational read port so that the result of each store can be observed.

Top module: `wa_store_adapter`

## Requirements
- R1: After reset `dev_we` is 0 and every word of the register bank reads 0.
- R2: `cpu_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A store accepted at a rising edge with `cpu_valid` high and kept by its class gives `dev_we` = 1 in exactly the next cycle, with `dev_addr` equal to the store address with bits 1:0 cleared. A dropped store gives `dev_we` = 0 in that cycle.
- R3: Plain memory region (address bits 7:4 in 0..3). A byte store writes `cpu_wdata[7:0]` into byte lane `addr[1:0]`. A halfword store writes `cpu_wdata[15:0]` into the half selected by `addr[1]`. A word store writes all 32 bits and ignores `addr[1:0]`.
- R4: Shifting word region (bits 7:4 = 4). A store of any size writes all 32 bits with the value `cpu_wdata << (8*addr[1:0])`. Bits shifted past bit 31 are lost and vacated bits become 0.
- R5: Widening half region (bits 7:4 = 5). A store of any size writes 16 bits into the half selected by `addr[1]`. The value is `cpu_wdata[15:0]` at an even address and `{cpu_wdata[7:0], 8'h00}` at an odd address. The other half is unchanged.
- R6: Strict word region (bits 7:4 = 6). A store writes all 32 bits of `cpu_wdata` when `addr[1:0]` = 0 and is discarded otherwise.
- R7: Strict half region (bits 7:4 = 7). A store writes `cpu_wdata[15:0]` into the half selected by `addr[1]` when `addr[0]` = 0 and is discarded otherwise.
- R8: Cropping region (bits 7:4 = 8). A word store writes only `cpu_wdata[15:0]` into the low half and leaves the upper half unchanged. Byte and halfword stores behave as in R5.
- R9: Ignored region (bits 7:4 = 9..15). Stores of every size are discarded, and the bank is left unchanged.
- R10: Stores on consecutive cycles each produce their own device write on consecutive cycles. Where the two writes overlap in bytes, the later store wins.
- R11: `rd_data` shows the bank word indexed by `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Store strobe, one store per high cycle |
| cpu_addr | input | 8 | Byte address of the store |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| cpu_wdata | input | 32 | Full source register value, unmasked |
| dev_we | output | 1 | Device write strobe |
| dev_addr | output | 8 | Word-aligned device address |
| dev_be | output | 4 | Byte enables of the device write |
| dev_wdata | output | 32 | Shaped device write data |
| rd_addr | input | 6 | Word index for the observation read |
| rd_data | output | 32 | Bank word at `rd_addr` |

## Verification
Two events can fall in the same cycle: the bank merges the device write of one store while the adapter decodes and shapes the next store. The bench provokes this by driving two stores on consecutive cycles to the same word. In one case they touch different halves of a widening register. In the other they write the same byte lane of plain memory. The merged word is then read back and compared with a byte-level model. The result is judged correct only if both writes land and the later store wins where they overlap.

// File: rtl/wa_pkg.sv
package wa_pkg;

    typedef enum logic [2:0] {
        CL_MEM,
        CL_SHIFT32,
        CL_WIDEN16,
        CL_STRICT32,
        CL_STRICT16,
        CL_CROP,
        CL_IGNORE
    } wa_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_DISCARD
    } wa_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        logic        keep;
        logic [3:0]  be;
        logic [31:0] data;
    } wa_shaped_t;

endpackage

// File: rtl/wa_decode.sv
module wa_decode
    import wa_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output wa_class_e         cls
);
    logic [3:0] region;
    assign region = addr[ADDR_W-1 -: 4];

    always_comb begin
        unique case (region)
            4'd0, 4'd1, 4'd2, 4'd3: cls = CL_MEM;
            4'd4:                   cls = CL_SHIFT32;
            4'd5:                   cls = CL_WIDEN16;
            4'd6:                   cls = CL_STRICT32;
            4'd7:                   cls = CL_STRICT16;
            4'd8:                   cls = CL_CROP;
            default:                cls = CL_IGNORE;
        endcase
    end
endmodule

// File: rtl/wa_shape.sv
module wa_shape
    import wa_pkg::*;
(
    input  wa_class_e   cls,
    input  logic [1:0]  ofs,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output wa_shaped_t  shaped
);
    logic [31:0] lane_shift;
    logic [15:0] widened;
    logic [3:0]  half_be;
    logic [31:0] half_dup;

    assign lane_shift = wdata << {ofs, 3'b000};
    assign widened    = ofs[0] ? {wdata[7:0], 8'h00} : wdata[15:0];
    assign half_be    = ofs[1] ? 4'b1100 : 4'b0011;
    assign half_dup   = {wdata[15:0], wdata[15:0]};

    always_comb begin
        shaped = '{keep: 1'b1, be: 4'hF, data: wdata};
        unique case (cls)
            CL_MEM: begin
                if (size == SZ_BYTE) begin
                    shaped.be   = 4'b0001 << ofs;
                    shaped.data = lane_shift;
                end else if (size == SZ_HALF) begin
                    shaped.be   = half_be;
                    shaped.data = half_dup;
                end
            end
            CL_SHIFT32: shaped.data = lane_shift;
            CL_WIDEN16: begin
                shaped.be   = half_be;
                shaped.data = {widened, widened};
            end
            CL_STRICT32: shaped.keep = (ofs == 2'd0);
            CL_STRICT16: begin
                shaped.keep = ~ofs[0];
                shaped.be   = half_be;
                shaped.data = half_dup;
            end
            CL_CROP: begin
                if (size == SZ_BYTE || size == SZ_HALF) begin
                    shaped.be   = half_be;
                    shaped.data = {widened, widened};
                end else begin
                    shaped.be   = 4'b0011;
                    shaped.data = half_dup;
                end
            end
            CL_IGNORE: shaped.keep = 1'b0;
            default:   shaped.keep = 1'b0;
        endcase
    end
endmodule

// File: rtl/wa_bank.sv
module wa_bank #(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/wa_store_adapter.sv
module wa_store_adapter
    import wa_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_wdata,
    output logic              dev_we,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [3:0]        dev_be,
    output logic [31:0]       dev_wdata,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [31:0]       rd_data
);
    wa_class_e  cls;
    wa_shaped_t shaped;
    wa_state_e  state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [3:0]       be_q;
    logic [31:0]      data_q;

    wa_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (cpu_addr),
        .cls  (cls)
    );

    wa_shape u_shape (
        .cls    (cls),
        .ofs    (cpu_addr[1:0]),
        .size   (cpu_size),
        .wdata  (cpu_wdata),
        .shaped (shaped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_DISCARD: begin
                if (!cpu_valid)       state_d = ST_IDLE;
                else if (shaped.keep) state_d = ST_WRITE;
                else                  state_d = ST_DISCARD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else if (cpu_valid && shaped.keep) begin
            idx_q  <= cpu_addr[ADDR_W-1:2];
            be_q   <= shaped.be;
            data_q <= shaped.data;
        end
    end

    assign dev_we    = (state_q == ST_WRITE);
    assign dev_addr  = {idx_q, 2'b00};
    assign dev_be    = be_q;
    assign dev_wdata = data_q;

    wa_bank #(.IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dev_we),
        .widx  (idx_q),
        .be    (be_q),
        .wdata (data_q),
        .ridx  (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/wa_store_adapter_chk.sv
module wa_store_adapter_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              dev_we,
    input logic [ADDR_W-1:0] dev_addr,
    input logic [3:0]        dev_be
);
    logic armed;
    always_ff @(posedge clk) armed <= rst_n;

    logic [3:0] region;
    assign region = cpu_addr[ADDR_W-1 -: 4];

    a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(cpu_valid) |-> !dev_we);

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> dev_addr[1:0] == 2'b00);

    a_r2_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_valid) && dev_we |-> dev_addr[ADDR_W-1:2] == $past(cpu_addr[ADDR_W-1:2]));

    a_r4_full_enables: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_valid && region == 4'd4) |-> dev_we && dev_be == 4'hF);

    a_r5_half_enables: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_valid && region == 4'd5) |-> dev_we && $countones(dev_be) == 2);

    a_r6_misaligned_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_valid && region == 4'd6 && cpu_addr[1:0] != 2'd0) |-> !dev_we);

    a_r9_ignore_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(cpu_valid && region >= 4'd9) |-> !dev_we);
endmodule

bind wa_store_adapter wa_store_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .dev_we    (dev_we),
    .dev_addr  (dev_addr),
    .dev_be    (dev_be)
);

// File: tb/test_wa_store_adapter.sv
module test_wa_store_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        dev_we;
    logic [7:0]  dev_addr;
    logic [3:0]  dev_be;
    logic [31:0] dev_wdata;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] model [64];

    always #10 clk = ~clk;

    wa_store_adapter i_wa_store_adapter (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] a);
        case (a[7:4])
            4'd0, 4'd1, 4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Byte-level model of the bank after a store; returns whether a write is due.
    function automatic bit apply(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        logic [31:0] w;
        int o, h;
        logic [15:0] v;
        bit word;
        w = model[a[7:2]];
        o = int'(a[1:0]);
        h = a[1] ? 16 : 0;
        word = (s >= 2'd2);
        v = (o % 2 == 1) ? {d[7:0], 8'h00} : d[15:0];
        case (a[7:4])
            4'd0, 4'd1, 4'd2, 4'd3: begin
                if (s == 2'd0)      w[8*o +: 8] = d[7:0];
                else if (s == 2'd1) w[h +: 16] = d[15:0];
                else                w = d;
            end
            4'd4: w = d << (8 * o);
            4'd5: w[h +: 16] = v;
            4'd6: begin if (o != 0) return 0; w = d; end
            4'd7: begin if (o % 2 == 1) return 0; w[h +: 16] = d[15:0]; end
            4'd8: begin if (word) w[15:0] = d[15:0]; else w[h +: 16] = v; end
            default: return 0;
        endcase
        model[a[7:2]] = w;
        return 1;
    endfunction

    task automatic read_check(input logic [7:0] a, input string req);
        rd_addr = a[7:2];
        #1;
        check(rd_data == model[a[7:2]], req, rd_data, model[a[7:2]]);
    endtask

    task automatic store(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        bit keep;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_size = s; cpu_wdata = d;
        keep = apply(a, s, d);
        @(negedge clk);
        cpu_valid = 1'b0;
        check(dev_we == keep, "R2", {31'b0, dev_we}, {31'b0, keep});
        if (keep) check(dev_addr == {a[7:2], 2'b00}, "R2", {24'b0, dev_addr}, {24'b0, a[7:2], 2'b00});
        @(negedge clk);
        read_check(a, req_of(a));
    endtask

    task automatic store_pair(input logic [7:0] a0, input logic [1:0] s0, input logic [31:0] d0,
                              input logic [7:0] a1, input logic [1:0] s1, input logic [31:0] d1);
        bit k0, k1;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a0; cpu_size = s0; cpu_wdata = d0;
        k0 = apply(a0, s0, d0);
        @(negedge clk);
        cpu_addr = a1; cpu_size = s1; cpu_wdata = d1;
        k1 = apply(a1, s1, d1);
        check(dev_we == k0, "R10", {31'b0, dev_we}, {31'b0, k0});
        @(negedge clk);
        cpu_valid = 1'b0;
        check(dev_we == k1, "R10", {31'b0, dev_we}, {31'b0, k1});
        @(negedge clk);
        read_check(a0, "R10");
        read_check(a1, "R10");
    endtask

    initial begin
        for (int w = 0; w < 64; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dev_we == 1'b0, "R1", {31'b0, dev_we}, 32'd0);
        for (int w = 0; w < 64; w++) begin
            rd_addr = 6'(w);
            #1;
            check(rd_data == 32'd0, "R1", rd_data, 32'd0);
        end
        // R3..R9, R11: every address, every size, unmasked data
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 256; a++) begin
                logic [31:0] d;
                d = 32'h9E37_79B9 ^ {8'(a), 8'(a * 3), 8'(~a), 8'(a + s)} ^ (32'(s) << 28);
                store(8'(a), 2'(s), d);
            end
        end
        // R10: back-to-back stores to the same word
        store_pair(8'h54, 2'd1, 32'hDEAD_1234, 8'h56, 2'd0, 32'hBEEF_00AB);
        store_pair(8'h09, 2'd0, 32'h1111_11C1, 8'h09, 2'd0, 32'h2222_22D2);
        store_pair(8'h80, 2'd2, 32'hCAFE_F00D, 8'h82, 2'd1, 32'h0000_7E57);
        store_pair(8'h61, 2'd2, 32'h0BAD_0BAD, 8'h60, 2'd2, 32'h600D_600D);
        print_summary();
    end

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        print_summary();
    end
endmodule